// File: doc/BRIEF.md
# Memory Bus Turnaround Timing Enforcer

This block sits between the command scheduler and the command bus of a graphics-memory controller. It remembers the direction of the last data command it granted, read or write. It lets further commands in that direction through in the same cycle they are requested. A command in the opposite direction is held back until a turnaround gap has passed. All gaps are counted in command clocks.

The read-to-write gap is worked out at run time from the programmed CAS latency and write latency. The burst length is fixed at 8 beats, so the burst term is always two clocks. The write-to-read gap comes from its own programmable register. Every command clock in which a request is held back costs four data beats, because the data clock runs at twice the command clock and transfers on both edges. A wrapping counter adds up these lost beats so that performance can be monitored.

The controller is a five-state machine:
- `ST_IDLE`: nothing has been granted since reset.
- `ST_RD_OPEN`: the last grant was a read.
- `ST_WR_OPEN`: the last grant was a write.
- `ST_RD_TO_WR`: a write is waiting out a read-to-write countdown.
- `ST_WR_TO_RD`: a read is waiting out a write-to-read countdown.

The transitions are:
- first grant: `ST_IDLE` goes to `ST_RD_OPEN` or `ST_WR_OPEN`, following the request direction.
- direction change: `ST_RD_OPEN` goes to `ST_RD_TO_WR`, and `ST_WR_OPEN` goes to `ST_WR_TO_RD`. This transition loads the countdown.
- countdown expiry: `ST_RD_TO_WR` goes to `ST_WR_OPEN`, and `ST_WR_TO_RD` goes to `ST_RD_OPEN`, when the held request is granted.
- cancel: a request in the old direction during a countdown is granted, and the machine returns to the open state of that direction.

Top module: `mem_turnaround_guard`

## Requirements
- R1: After reset, `grant`, `stall` and `lost_beats` are 0. The latency registers return to CAS 12, write latency 5 and write-to-read gap 7. The first request after reset is granted in its own cycle, whatever its direction.
- R2: A request in the same direction as the last granted command is granted in the cycle it is presented, so back-to-back requests in one direction are granted every cycle.
- R3: After a read has been granted, a write request is stalled for exactly G = CL + 2 + 2 - WL cycles, counted from its first valid cycle, and is granted in the next cycle. With the reset values, G is 11.
- R4: After a write has been granted, a read request is stalled for exactly the programmed write-to-read gap (7 after reset) and is granted in the next cycle.
- R5: A read-to-write result of zero or less is replaced by 1. A programmed write-to-read gap of 0 is also treated as 1.
- R6: `stall` is high exactly when `req_valid` is high and `grant` is low. Once loaded, the countdown keeps running even if the request is withdrawn. An opposite-direction request that arrives after the countdown has expired is granted at once.
- R7: During a countdown, a request in the direction that was last granted is granted at once and cancels the countdown.
- R8: `lost_beats` goes up by 4 (modulo 2^16) at every clock edge where `stall` was high. Otherwise it holds its value.
- R9: A configuration write is taken only when no countdown is running, that is, unless the machine is in a countdown state with a nonzero remaining count. A write made during a running countdown is ignored.
- R10: `cfg_we` loads all three registers together: `cfg_cas_lat` (5 bits), `cfg_wr_lat` (4 bits) and `cfg_w2r_gap` (5 bits). `req_dir` is 0 for a read and 1 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Scheduler offers a data command |
| req_dir | input | 1 | Direction of the offered command: 0 for read, 1 for write |
| cfg_we | input | 1 | Load the latency registers |
| cfg_cas_lat | input | 5 | New CAS latency in command clocks |
| cfg_wr_lat | input | 4 | New write latency in command clocks |
| cfg_w2r_gap | input | 5 | New write-to-read gap in command clocks |
| grant | output | 1 | Command may go on the bus this cycle |
| stall | output | 1 | Offered command is held back by turnaround |
| lost_beats | output | 16 | Wrapping count of data beats lost to turnaround |

## Verification
The main function is driven with these request patterns:
- Runs in one direction, which show that same-direction traffic is never delayed.
- Alternating read and write runs, which show the two different gap lengths.
- A switch that is cancelled by a return to the old direction, which separates the cancel path from the countdown-expiry path.
- A request that is withdrawn while its countdown is running, which shows that the countdown keeps going without the request.

Further cases cover gap settings and configuration timing:
- Long gaps, short gaps and clamped gaps, which show that the read-to-write gap really follows the programmed latencies and is not a constant.
- A configuration write issued in the middle of a countdown, compared with one issued while no countdown is running.
- A reset in the middle of a run, which shows that the defaults come back.

// File: rtl/tat_pkg.sv
package tat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_OPEN  = 3'd1,
        ST_WR_OPEN  = 3'd2,
        ST_RD_TO_WR = 3'd3,
        ST_WR_TO_RD = 3'd4
    } bus_state_e;

    localparam logic DIR_READ  = 1'b0;
    localparam logic DIR_WRITE = 1'b1;

endpackage

// File: rtl/tat_cfg_regs.sv
module tat_cfg_regs #(
    parameter int CL_W    = 5,
    parameter int WL_W    = 4,
    parameter int W2R_W   = 5,
    parameter int RST_CL  = 12,
    parameter int RST_WL  = 5,
    parameter int RST_W2R = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             busy,
    input  logic [CL_W-1:0]  cl_in,
    input  logic [WL_W-1:0]  wl_in,
    input  logic [W2R_W-1:0] w2r_in,
    output logic [CL_W-1:0]  cl_q,
    output logic [WL_W-1:0]  wl_q,
    output logic [W2R_W-1:0] w2r_q
);

    // A write is accepted only when no countdown depends on the current values.
    logic accept;

    always_comb begin
        accept = wr_en && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cl_q  <= CL_W'(RST_CL);
            wl_q  <= WL_W'(RST_WL);
            w2r_q <= W2R_W'(RST_W2R);
        end else if (accept) begin
            cl_q  <= cl_in;
            wl_q  <= wl_in;
            w2r_q <= w2r_in;
        end
    end

endmodule

// File: rtl/tat_gap_calc.sv
module tat_gap_calc #(
    parameter int CL_W      = 5,
    parameter int WL_W      = 4,
    parameter int W2R_W     = 5,
    parameter int BURST_LEN = 8,
    parameter int GAP_W     = 6
) (
    input  logic [CL_W-1:0]  cl,
    input  logic [WL_W-1:0]  wl,
    input  logic [W2R_W-1:0] w2r,
    output logic [GAP_W-1:0] r2w_gap,
    output logic [GAP_W-1:0] w2r_gap
);

    // Fixed part of the read-to-write gap: burst term plus bus settle.
    localparam int FIXED_TERM = BURST_LEN / 4 + 2;
    localparam int BASE_W     = (GAP_W > WL_W) ? GAP_W : WL_W;
    localparam int SUM_W      = BASE_W + 1;

    logic [SUM_W-1:0] lead;
    logic [SUM_W-1:0] lag;
    logic [SUM_W-1:0] diff;

    always_comb begin
        lead = SUM_W'(cl) + SUM_W'(FIXED_TERM);
        lag  = SUM_W'(wl);
        diff = lead - lag;
        // A result of zero or below becomes a single clock.
        if (lead > lag) begin
            r2w_gap = GAP_W'(diff);
        end else begin
            r2w_gap = GAP_W'(1);
        end
    end

    always_comb begin
        if (w2r == '0) begin
            w2r_gap = GAP_W'(1);
        end else begin
            w2r_gap = GAP_W'(w2r);
        end
    end

endmodule

// File: rtl/tat_dir_fsm.sv
module tat_dir_fsm
    import tat_pkg::*;
#(
    parameter int GAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_dir,
    input  logic [GAP_W-1:0] r2w_gap,
    input  logic [GAP_W-1:0] w2r_gap,
    output logic             grant,
    output logic             stall,
    output logic             busy
);

    bus_state_e       state_q, state_n;
    logic [GAP_W-1:0] cnt_q, cnt_n;
    logic             cnt_zero;
    logic             want_rd;
    logic             want_wr;

    always_comb begin
        cnt_zero = (cnt_q == '0);
        want_rd  = req_valid && (req_dir == DIR_READ);
        want_wr  = req_valid && (req_dir == DIR_WRITE);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state and countdown
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (want_rd) begin
                    state_n = ST_RD_OPEN;
                end else if (want_wr) begin
                    state_n = ST_WR_OPEN;
                end
            end
            ST_RD_OPEN: begin
                if (want_wr) begin
                    state_n = ST_RD_TO_WR;
                    cnt_n   = GAP_W'(r2w_gap - 1'b1);
                end
            end
            ST_WR_OPEN: begin
                if (want_rd) begin
                    state_n = ST_WR_TO_RD;
                    cnt_n   = GAP_W'(w2r_gap - 1'b1);
                end
            end
            ST_RD_TO_WR: begin
                if (!cnt_zero) begin
                    cnt_n = GAP_W'(cnt_q - 1'b1);
                end
                if (want_rd) begin
                    state_n = ST_RD_OPEN;
                end else if (want_wr && cnt_zero) begin
                    state_n = ST_WR_OPEN;
                end
            end
            ST_WR_TO_RD: begin
                if (!cnt_zero) begin
                    cnt_n = GAP_W'(cnt_q - 1'b1);
                end
                if (want_wr) begin
                    state_n = ST_WR_OPEN;
                end else if (want_rd && cnt_zero) begin
                    state_n = ST_RD_OPEN;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        grant = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            ST_IDLE:     grant = req_valid;
            ST_RD_OPEN:  grant = want_rd;
            ST_WR_OPEN:  grant = want_wr;
            ST_RD_TO_WR: begin
                grant = want_rd || (want_wr && cnt_zero);
                busy  = !cnt_zero;
            end
            ST_WR_TO_RD: begin
                grant = want_wr || (want_rd && cnt_zero);
                busy  = !cnt_zero;
            end
            default:     grant = 1'b0;
        endcase
        stall = req_valid && !grant;
    end

endmodule

// File: rtl/tat_beat_counter.sv
module tat_beat_counter #(
    parameter int LOST_W = 16,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    output logic [LOST_W-1:0] lost_beats
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_beats <= '0;
        end else if (stall) begin
            lost_beats <= lost_beats + LOST_W'(BEATS);
        end
    end

endmodule

// File: rtl/mem_turnaround_guard.sv
module mem_turnaround_guard #(
    parameter int CL_W           = 5,
    parameter int WL_W           = 4,
    parameter int W2R_W          = 5,
    parameter int BURST_LEN      = 8,
    parameter int DATA_CLK_RATIO = 2,
    parameter int LOST_W         = 16,
    parameter int RST_CL         = 12,
    parameter int RST_WL         = 5,
    parameter int RST_W2R        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic              cfg_we,
    input  logic [CL_W-1:0]   cfg_cas_lat,
    input  logic [WL_W-1:0]   cfg_wr_lat,
    input  logic [W2R_W-1:0]  cfg_w2r_gap,
    output logic              grant,
    output logic              stall,
    output logic [LOST_W-1:0] lost_beats
);

    // Beats lost per stalled command clock: double-rate clock, both edges.
    localparam int BEATS_PER_CLK = DATA_CLK_RATIO * 2;
    localparam int R2W_MAX       = (1 << CL_W) - 1 + BURST_LEN / 4 + 2;
    localparam int W2R_MAX       = (1 << W2R_W) - 1;
    localparam int GAP_MAX       = (R2W_MAX > W2R_MAX) ? R2W_MAX : W2R_MAX;
    localparam int GAP_W         = $clog2(GAP_MAX + 1);

    logic [CL_W-1:0]  cl_q;
    logic [WL_W-1:0]  wl_q;
    logic [W2R_W-1:0] w2r_q;
    logic [GAP_W-1:0] r2w_gap;
    logic [GAP_W-1:0] w2r_gap;
    logic             busy;

    tat_cfg_regs #(
        .CL_W   (CL_W),
        .WL_W   (WL_W),
        .W2R_W  (W2R_W),
        .RST_CL (RST_CL),
        .RST_WL (RST_WL),
        .RST_W2R(RST_W2R)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .busy  (busy),
        .cl_in (cfg_cas_lat),
        .wl_in (cfg_wr_lat),
        .w2r_in(cfg_w2r_gap),
        .cl_q  (cl_q),
        .wl_q  (wl_q),
        .w2r_q (w2r_q)
    );

    tat_gap_calc #(
        .CL_W     (CL_W),
        .WL_W     (WL_W),
        .W2R_W    (W2R_W),
        .BURST_LEN(BURST_LEN),
        .GAP_W    (GAP_W)
    ) u_gap (
        .cl     (cl_q),
        .wl     (wl_q),
        .w2r    (w2r_q),
        .r2w_gap(r2w_gap),
        .w2r_gap(w2r_gap)
    );

    tat_dir_fsm #(
        .GAP_W(GAP_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_dir  (req_dir),
        .r2w_gap  (r2w_gap),
        .w2r_gap  (w2r_gap),
        .grant    (grant),
        .stall    (stall),
        .busy     (busy)
    );

    tat_beat_counter #(
        .LOST_W(LOST_W),
        .BEATS (BEATS_PER_CLK)
    ) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .lost_beats(lost_beats)
    );

endmodule

// File: rtl/tat_guard_chk.sv
module tat_guard_chk #(
    parameter int LOST_W = 16,
    parameter int BEATS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_dir,
    input logic              grant,
    input logic              stall,
    input logic [LOST_W-1:0] lost_beats
);

    // R6
    resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || stall) |-> req_valid);

    // R6
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (grant != stall));

    // R8
    beat_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (lost_beats == LOST_W'($past(lost_beats) + LOST_W'(BEATS))));

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> $stable(lost_beats));

    // R2
    same_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (!(req_valid && (req_dir == $past(req_dir))) || grant));

    // R3
    switch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (!(req_valid && (req_dir != $past(req_dir))) || stall));

endmodule

bind mem_turnaround_guard tat_guard_chk #(
    .LOST_W(LOST_W),
    .BEATS (BEATS_PER_CLK)
) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dir   (req_dir),
    .grant     (grant),
    .stall     (stall),
    .lost_beats(lost_beats)
);

// File: tb/mem_turnaround_guard_test.sv
module mem_turnaround_guard_test;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_dir;
    logic        cfg_we;
    logic [4:0]  cfg_cas_lat;
    logic [3:0]  cfg_wr_lat;
    logic [4:0]  cfg_w2r_gap;
    logic        grant;
    logic        stall;
    logic [15:0] lost_beats;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    mem_turnaround_guard uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_dir    (req_dir),
        .cfg_we     (cfg_we),
        .cfg_cas_lat(cfg_cas_lat),
        .cfg_wr_lat (cfg_wr_lat),
        .cfg_w2r_gap(cfg_w2r_gap),
        .grant      (grant),
        .stall      (stall),
        .lost_beats (lost_beats)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct packed {
        logic       v;
        logic       d;
        logic       g;
        logic       s;
        logic [7:0] reps;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd2},   // R1 R2 first reads
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd11},  // R3 read to write, gap 11
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd3},   // R2 writes
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd7},   // R4 write to read, gap 7
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd2},   // R6 no request
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd11},  // R3
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd3},   // R4 partial countdown
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd1},   // R7 cancel back to write
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd7},   // R4 fresh countdown
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic d);
        @(negedge clk);
        req_valid = v;
        req_dir   = d;
        cfg_we    = 1'b0;
        #1;
    endtask

    task automatic run_until_grant(input logic d, output int stalls);
        stalls = 0;
        for (int i = 0; i < 100; i++) begin
            drive(1'b1, d);
            if (grant) break;
            stalls++;
        end
    endtask

    task automatic cfg_write(input int cl, input int wl, input int w2r);
        @(negedge clk);
        req_valid   = 1'b0;
        cfg_we      = 1'b1;
        cfg_cas_lat = 5'(cl);
        cfg_wr_lat  = 4'(wl);
        cfg_w2r_gap = 5'(w2r);
        @(negedge clk);
        cfg_we      = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s;
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_dir     = 1'b0;
        cfg_we      = 1'b0;
        cfg_cas_lat = '0;
        cfg_wr_lat  = '0;
        cfg_w2r_gap = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(grant == 1'b0 && stall == 1'b0, "R1 reset outputs", int'(grant) + int'(stall), 0);
        check(lost_beats == 16'd0, "R1 reset lost_beats", int'(lost_beats), 0);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            for (int r = 0; r < int'(VECS[k].reps); r++) begin
                drive(VECS[k].v, VECS[k].d);
                check(grant == VECS[k].g, $sformatf("R2 R3 R4 R6 R7 vec %0d grant", k),
                      int'(grant), int'(VECS[k].g));
                check(stall == VECS[k].s, $sformatf("R6 vec %0d stall", k),
                      int'(stall), int'(VECS[k].s));
            end
        end
        drive(1'b0, 1'b0);
        // R8 39 stalled clocks -> 156 beats
        check(lost_beats == 16'd156, "R8 lost beats after table", int'(lost_beats), 156);

        // R6 request withdrawn during countdown (state: read open)
        drive(1'b1, 1'b1);
        check(stall == 1'b1, "R6 switch stalls", int'(stall), 1);
        for (int i = 0; i < 12; i++) drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check(grant == 1'b1, "R6 expired countdown grants", int'(grant), 1);
        check(lost_beats == 16'd160, "R8 lost beats after withdraw", int'(lost_beats), 160);

        // R9 R10 accepted write while open: CL=20 WL=4 W2R=3
        cfg_write(20, 4, 3);
        run_until_grant(1'b0, s);
        check(s == 3, "R4 programmed w2r gap", s, 3);
        run_until_grant(1'b1, s);
        check(s == 20, "R3 programmed r2w gap", s, 20);

        // R9 write during running countdown is ignored
        drive(1'b1, 1'b0);
        check(stall == 1'b1, "R9 first stall", int'(stall), 1);
        @(negedge clk);
        req_valid   = 1'b1;
        req_dir     = 1'b0;
        cfg_we      = 1'b1;
        cfg_cas_lat = 5'd5;
        cfg_wr_lat  = 4'd7;
        cfg_w2r_gap = 5'd1;
        #1;
        check(stall == 1'b1, "R9 stall during write", int'(stall), 1);
        run_until_grant(1'b0, s);
        check(s == 1, "R9 countdown unchanged", s, 1);
        run_until_grant(1'b1, s);
        check(s == 20, "R9 r2w gap kept", s, 20);
        run_until_grant(1'b0, s);
        check(s == 3, "R9 w2r gap kept", s, 3);

        // R5 clamps: CL=0 WL=15 W2R=0
        cfg_write(0, 15, 0);
        run_until_grant(1'b1, s);
        check(s == 1, "R5 r2w clamp", s, 1);
        run_until_grant(1'b0, s);
        check(s == 1, "R5 w2r clamp", s, 1);

        // R1 mid-run reset restores defaults
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        #1;
        check(lost_beats == 16'd0, "R1 lost cleared", int'(lost_beats), 0);
        check(grant == 1'b0 && stall == 1'b0, "R1 outputs cleared", int'(grant) + int'(stall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_until_grant(1'b1, s);
        check(s == 0, "R1 first write granted at once", s, 0);
        run_until_grant(1'b0, s);
        check(s == 7, "R1 default w2r gap", s, 7);
        run_until_grant(1'b1, s);
        check(s == 11, "R1 default r2w gap", s, 11);
        drive(1'b0, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule